// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

Two agents share one memory array, each through its own port. This block gives them a way to signal each other. Two word addresses at the top of the address space act as mailboxes. The highest address belongs to the right port. The address just below it belongs to the left port. When one port writes into the other port's mailbox, the owner of that mailbox receives an interrupt. The interrupt stays asserted until the owner reads its own mailbox. The message words are stored in the ordinary array, which is outside this block. Only the decode and the two interrupt flags are inside.

The block watches the read strobe, write strobe and address of each port. A busy input comes from the collision arbiter for each port. While a port's busy is high, its accesses have no effect on the flags: its write cannot raise the other side's interrupt, and its read of its own mailbox cannot clear its own interrupt. The interrupt outputs are registered and active low. If a flag is set and cleared in the same cycle, the set wins.

Top module: `mbx_irq`

## Requirements
- R1: While `rst` is high, `l_int_n` and `r_int_n` are both 1 at every following clock edge.
- R2: A left write (`l_wr`=1) to address all-ones with `l_busy`=0 drives `r_int_n` to 0 one clock after the edge that samples it.
- R3: A right write (`r_wr`=1) to address all-ones minus one with `r_busy`=0 drives `l_int_n` to 0 one clock after the edge that samples it.
- R4: A port that reads its own mailbox clears its own interrupt (its `*_int_n` goes to 1) one clock later, provided its busy is 0 and the other port does not set the same flag in that cycle. The right mailbox is address all-ones and the left mailbox is address all-ones minus one.
- R5: A port that reads the other port's mailbox does not change either interrupt.
- R6: A write with that port's busy at 1 does not set the other port's interrupt.
- R7: A read of its own mailbox with that port's busy at 1 does not clear the interrupt.
- R8: A set and a clear of the same flag in the same cycle leave that flag active (`*_int_n`=0).
- R9: Writes by a port to its own mailbox, and accesses to any address other than the two mailboxes, change neither interrupt.
- R10: With no qualifying set or clear, each interrupt output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_wr | input | 1 | Left port write strobe, one access per cycle |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | AW | Left port word address |
| l_busy | input | 1 | Arbiter busy to the left port |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | AW | Right port word address |
| r_busy | input | 1 | Arbiter busy to the right port |
| l_int_n | output | 1 | Left port interrupt, active low |
| r_int_n | output | 1 | Right port interrupt, active low |

## Verification
Every result is due exactly one clock after the edge that samples the strobes. The decode is combinational and the flag is the only register between an input and an output. The bench therefore applies each stimulus after a falling edge. It updates its own flag model at the next rising edge and compares both outputs a short delay after that edge, before the next stimulus is applied. Directed cases cover collisions of a set and a clear, and the two busy blocks. After them, seeded random traffic is biased towards the two mailbox addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;

  // distance of a port's own mailbox below the all-ones address
  function automatic int unsigned own_offset(port_e p);
    return (p == PORT_R) ? 0 : 1;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int AW       = 15,
  parameter int OWN_OFS  = 0,
  parameter int PEER_OFS = 1
) (
  input  logic [AW-1:0] addr,
  output logic          own_hit,
  output logic          peer_hit
);
  localparam logic [AW-1:0] TOP      = {AW{1'b1}};
  localparam logic [AW-1:0] OWN_ADR  = TOP - AW'(OWN_OFS);
  localparam logic [AW-1:0] PEER_ADR = TOP - AW'(PEER_OFS);

  always_comb begin
    own_hit  = (addr == OWN_ADR);
    peer_hit = (addr == PEER_ADR);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic int_n
);
  always_ff @(posedge clk) begin
    if (rst)        int_n <= 1'b1;
    else if (set_i) int_n <= 1'b0;
    else if (clr_i) int_n <= 1'b1;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !int_n) else $error("set did not take effect");
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> int_n) else $error("clear did not take effect");
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(int_n)) else $error("flag moved without cause");
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy,
  input  logic          r_wr,
  input  logic          r_rd,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy,
  output logic          l_int_n,
  output logic          r_int_n
);
  import mbx_pkg::*;
  localparam int NP = 2;

  logic [NP-1:0] wr, rd, busy, own_hit, peer_hit, set_v, clr_v, int_v;
  logic [AW-1:0] addr [NP];

  always_comb begin
    wr   = {r_wr, l_wr};
    rd   = {r_rd, l_rd};
    busy = {r_busy, l_busy};
    addr[PORT_L] = l_addr;
    addr[PORT_R] = r_addr;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam port_e ME   = port_e'(p);
    localparam port_e PEER = port_e'(NP - 1 - p);

    mbx_decode #(
      .AW(AW), .OWN_OFS(own_offset(ME)), .PEER_OFS(own_offset(PEER))
    ) i_dec (
      .addr(addr[p]), .own_hit(own_hit[p]), .peer_hit(peer_hit[p])
    );

    // flag p is set by the peer writing p's mailbox, cleared by p reading it
    always_comb begin
      set_v[p] = wr[NP-1-p] && peer_hit[NP-1-p] && !busy[NP-1-p];
      clr_v[p] = rd[p] && own_hit[p] && !busy[p];
    end

    mbx_flag i_flag (
      .clk(clk), .rst(rst), .set_i(set_v[p]), .clr_i(clr_v[p]), .int_n(int_v[p])
    );
  end

  always_comb begin
    l_int_n = int_v[PORT_L];
    r_int_n = int_v[PORT_R];
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (l_int_n && r_int_n)) else $error("reset state wrong");
  p_lbusy_blocks_set_r6: assert property (@(posedge clk) disable iff (rst)
    (r_int_n && l_busy) |=> r_int_n) else $error("busy left write set right flag");
  p_rbusy_blocks_set_r6: assert property (@(posedge clk) disable iff (rst)
    (l_int_n && r_busy) |=> l_int_n) else $error("busy right write set left flag");
  p_rbusy_blocks_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (!r_int_n && r_busy) |=> !r_int_n) else $error("busy right read cleared flag");
  p_lbusy_blocks_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (!l_int_n && l_busy) |=> !l_int_n) else $error("busy left read cleared flag");
endmodule

// File: tb/test_mbx_irq.sv
module test_mbx_irq;
  localparam int AW = 15;
  localparam logic [AW-1:0] RMB = {AW{1'b1}};
  localparam logic [AW-1:0] LMB = RMB - 1'b1;

  logic clk = 1'b0, rst = 1'b1;
  logic l_wr = 0, l_rd = 0, l_busy = 0, r_wr = 0, r_rd = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_int_n, r_int_n;
  logic exp_l = 1'b1, exp_r = 1'b1;   // expected active-low outputs
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_irq #(.AW(AW)) i_mbx_irq (.*);

  function automatic logic next_flag(logic cur_n, logic set, logic clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur_n;
  endfunction

  task automatic check(string req);
    checks++;
    if (l_int_n !== exp_l || r_int_n !== exp_r) begin
      fails++;
      $display("FAIL %s: l_int_n=%b r_int_n=%b expected l=%b r=%b",
               req, l_int_n, r_int_n, exp_l, exp_r);
    end
  endtask

  // apply one access pair, model the edge, check after it
  task automatic step(logic lw, logic lr, logic [AW-1:0] la, logic lb,
                      logic rw, logic rr, logic [AW-1:0] ra, logic rb, string req);
    @(negedge clk);
    l_wr = lw; l_rd = lr; l_addr = la; l_busy = lb;
    r_wr = rw; r_rd = rr; r_addr = ra; r_busy = rb;
    @(posedge clk);
    if (rst) begin
      exp_l = 1'b1; exp_r = 1'b1;
    end else begin
      exp_r = next_flag(exp_r, lw && la == RMB && !lb, rr && ra == RMB && !rb);
      exp_l = next_flag(exp_l, rw && ra == LMB && !rb, lr && la == LMB && !lb);
    end
    #1 check(req);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    step(1, 0, RMB, 0, 1, 0, LMB, 0, "R1 reset holds high");
    step(0, 0, '0, 0, 0, 0, '0, 0, "R1 reset holds high");
    rst = 1'b0;
    step(0, 0, '0, 0, 0, 0, '0, 0, "R10 idle after reset");
    step(1, 0, RMB, 0, 0, 0, '0, 0, "R2 left writes right mailbox");
    step(0, 0, '0, 0, 0, 0, '0, 0, "R10 right flag holds");
    step(0, 1, RMB, 0, 0, 1, LMB, 0, "R5 reads of peer mailbox");
    step(0, 0, '0, 0, 0, 1, RMB, 1, "R7 busy right read keeps flag");
    step(0, 0, '0, 0, 0, 1, RMB, 0, "R4 right read clears");
    step(0, 0, '0, 0, 1, 0, LMB, 0, "R3 right writes left mailbox");
    step(0, 1, LMB, 0, 1, 0, LMB, 0, "R8 set wins over clear");
    step(0, 1, LMB, 0, 0, 0, '0, 0, "R4 left read clears");
    step(1, 0, RMB, 1, 0, 0, '0, 0, "R6 busy left write blocked");
    step(0, 0, '0, 0, 1, 0, LMB, 1, "R6 busy right write blocked");
    step(1, 0, LMB, 0, 1, 0, RMB, 0, "R9 own mailbox writes ignored");
    step(1, 0, 15'h1234, 0, 1, 0, RMB - 2, 0, "R9 other address ignored");
    step(1, 0, RMB, 0, 0, 1, RMB, 0, "R8 right set wins");
    step(0, 1, LMB, 1, 0, 1, RMB, 0, "R4 clear right");
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a [2];
      for (int k = 0; k < 2; k++) begin
        case ($urandom % 4)
          0: a[k] = RMB;
          1: a[k] = LMB;
          2: a[k] = RMB - 2;
          default: a[k] = AW'($urandom);
        endcase
      end
      step(1'($urandom), 1'($urandom), a[0], ($urandom % 4) == 0,
           1'($urandom), 1'($urandom), a[1], ($urandom % 4) == 0,
           "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule